// File: doc/BRIEF.md
# Scanline Video Memory Slot Arbiter

This block decides, cycle by cycle, which client of a character/bitmap display controller may use the video memory. Five clients compete: the per-line pixel data fetch, DRAM refresh, the character-row prefetch, the attribute-row prefetch and a block-transfer DMA engine. Each cycle at most one of them receives the slot. The priority is fixed: line data first, then refresh, character row, attribute row and, last, DMA.

The block takes its timing from the scanline strobe, the display-region flag and the vertical blanking flag. It sets up every burst from configuration inputs: bytes per line, refresh accesses per line, character height, row count, text or bitmap mode, and attribute enable. It counts the row cadence itself. Each line, character and attribute burst starts with two setup slots that make no memory access. If a row prefetch is still running at the next row boundary, it is left to finish, and the new row's fetch is dropped. Any slot that remains goes to DMA.

A per-frame count of DMA slots lets a surrounding environment measure the bandwidth left for block transfers. The DRAM itself, the pixel path and the CPU register access lie outside this block.

Top module: `vram_slot_arbiter`

## Requirements
- R1: `gnt` is one-hot or zero. The bit positions are: bit 0 line fetch, bit 1 refresh, bit 2 character row, bit 3 attribute row, bit 4 DMA.
- R2: When several clients have slots outstanding, the grant goes to the lowest bit position among them.
- R3: A `line_start` with `in_display` high loads a line burst. From the next cycle, that burst needs 2 setup slots plus `bytes_per_line` data slots. `setup_slot` is high exactly while a setup slot of a line, character or attribute burst is granted. A new `line_start` reloads the burst.
- R4: Every `line_start` loads `refresh_cnt` refresh slots, with no setup slots, replacing any refresh slots still left.
- R5: A row trigger fires in the cycle in which `vblank` rises. It also fires on every `char_height`-th display `line_start` after that rise. Each frame has at most `rows`+1 triggers.
- R6: In text mode (`text_mode`=1), a row trigger starts a character burst of 2 setup slots plus `bytes_per_line` data slots. When `attr_en` is set, an attribute burst of the same length starts in the cycle after the character burst's last slot.
- R7: In bitmap mode (`text_mode`=0), no character burst runs. When `attr_en` is set, the row trigger starts the attribute burst directly.
- R8: A row trigger that arrives while a character or attribute burst is still outstanding is dropped. The running burst continues to completion.
- R9: `char_done` and `attr_done` pulse for one cycle, in the cycle after the last slot of the corresponding burst.
- R10: DMA is granted exactly when `dma_req` is high and no other client has slots outstanding. When neither holds, no slot is granted.
- R11: `dma_frame_cnt` counts DMA grants. It returns to 0 in the cycle after `vblank` rises, counting from that point on, and wraps at its width.
- R12: While reset is asserted, `gnt` is zero apart from DMA, and `setup_slot`, `char_done`, `attr_done` and `dma_frame_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_start | input | 1 | One-cycle strobe at the start of each scanline |
| in_display | input | 1 | Current scanline lies in the display region |
| vblank | input | 1 | Vertical blanking level; its rising edge starts a frame |
| dma_req | input | 1 | Block-transfer engine wants a slot |
| text_mode | input | 1 | 1 = text mode, 0 = bitmap mode |
| attr_en | input | 1 | Attribute fetch enabled |
| bytes_per_line | input | LEN_W | Data slots per line, character and attribute burst |
| refresh_cnt | input | REF_W | Refresh slots per scanline |
| char_height | input | CH_W | Scanlines per character row (1 or more) |
| rows | input | ROW_W | Displayed character rows |
| gnt | output | 5 | One-hot slot grant |
| setup_slot | output | 1 | Granted slot is a burst setup slot |
| char_done | output | 1 | Character burst completed |
| attr_done | output | 1 | Attribute burst completed |
| dma_frame_cnt | output | DC_W | DMA slots granted in the current frame |

## Verification
A corrupted slot counter inside one burst changes the burst's length. The first sign is the cycle in which that client's grant bit falls. This moves every lower-priority grant and the matching done pulse by the same number of cycles, so a lockstep reference shows the mismatch in the cycle the burst was due to end. A wrong row counter, or a wrong busy decision at a row trigger, shows up as a character or attribute burst that starts or is missing one cycle after the trigger line strobe. Across a frame, it also changes the number of `char_done` pulses. A wrong frame-start detector shows one cycle after `vblank` rises, as a DMA count that was not cleared.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  localparam int NUM_CLIENTS = 5;
  localparam int IX_LINE = 0;
  localparam int IX_REF  = 1;
  localparam int IX_CHAR = 2;
  localparam int IX_ATTR = 3;
  localparam int IX_DMA  = 4;
endpackage

// File: rtl/vsa_burst.sv
module vsa_burst #(
  parameter int LEN_W     = 8,
  parameter int SETUP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             take,
  output logic             active,
  output logic             in_setup,
  output logic             last
);
  localparam int SW = $clog2(SETUP_CYC + 2);

  logic [SW-1:0]    setup_q, setup_d;
  logic [LEN_W-1:0] rem_q, rem_d;

  always_comb begin
    setup_d = setup_q;
    rem_d   = rem_q;
    if (start) begin
      setup_d = SW'(SETUP_CYC);
      rem_d   = len;
    end else if (take) begin
      if (setup_q != '0)    setup_d = setup_q - SW'(1);
      else if (rem_q != '0) rem_d   = rem_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      rem_q   <= '0;
    end else begin
      setup_q <= setup_d;
      rem_q   <= rem_d;
    end
  end

  assign active   = (setup_q != '0) || (rem_q != '0);
  assign in_setup = (setup_q != '0);
  assign last     = take && (((setup_q == '0) && (rem_q == LEN_W'(1))) ||
                             ((setup_q == SW'(1)) && (rem_q == '0)));

  // R1
  take_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> active);
endmodule

// File: rtl/vsa_row_cadence.sv
module vsa_row_cadence #(
  parameter int CH_W  = 5,
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vblank,
  input  logic             line_start,
  input  logic             in_display,
  input  logic [CH_W-1:0]  char_height,
  input  logic [ROW_W-1:0] rows,
  output logic             frame_start,
  output logic             row_trig
);
  logic              vb_q;
  logic [CH_W-1:0]   lin_q, lin_d;
  logic [ROW_W:0]    cnt_q, cnt_d;

  assign frame_start = vblank && !vb_q;

  always_comb begin
    lin_d    = lin_q;
    cnt_d    = cnt_q;
    row_trig = 1'b0;
    if (frame_start) begin
      lin_d    = '0;
      cnt_d    = (ROW_W+1)'(1);
      row_trig = 1'b1;
    end else if (line_start && in_display) begin
      if (lin_q == char_height - CH_W'(1)) begin
        lin_d = '0;
        if (cnt_q <= {1'b0, rows}) begin
          row_trig = 1'b1;
          cnt_d    = cnt_q + (ROW_W+1)'(1);
        end
      end else begin
        lin_d = lin_q + CH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb_q  <= 1'b0;
      lin_q <= '0;
      cnt_q <= '0;
    end else begin
      vb_q  <= vblank;
      lin_q <= lin_d;
      cnt_q <= cnt_d;
    end
  end

  // R5
  trig_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_trig && !frame_start) |-> (cnt_q <= {1'b0, rows}));
endmodule

// File: rtl/vram_slot_arbiter.sv
module vram_slot_arbiter
  import vsa_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int REF_W     = 5,
  parameter int CH_W      = 5,
  parameter int ROW_W     = 7,
  parameter int DC_W      = 16,
  parameter int SETUP_CYC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   line_start,
  input  logic                   in_display,
  input  logic                   vblank,
  input  logic                   dma_req,
  input  logic                   text_mode,
  input  logic                   attr_en,
  input  logic [LEN_W-1:0]       bytes_per_line,
  input  logic [REF_W-1:0]       refresh_cnt,
  input  logic [CH_W-1:0]        char_height,
  input  logic [ROW_W-1:0]       rows,
  output logic [NUM_CLIENTS-1:0] gnt,
  output logic                   setup_slot,
  output logic                   char_done,
  output logic                   attr_done,
  output logic [DC_W-1:0]        dma_frame_cnt
);
  logic rst_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  logic frame_start, row_trig;
  vsa_row_cadence #(.CH_W(CH_W), .ROW_W(ROW_W)) u_cad (
    .clk(clk), .rst_n(rst_n_i), .vblank(vblank), .line_start(line_start),
    .in_display(in_display), .char_height(char_height), .rows(rows),
    .frame_start(frame_start), .row_trig(row_trig));

  logic [NUM_CLIENTS-1:0] act;
  logic ln_set, ch_set, at_set;
  logic ln_last, rf_last, ch_last, at_last;
  logic ln_start, ch_start, at_start, row_busy;

  assign ln_start = line_start && in_display;
  assign row_busy = act[IX_CHAR] || act[IX_ATTR];
  assign ch_start = row_trig && text_mode && !row_busy;
  assign at_start = attr_en && !act[IX_ATTR] &&
                    (text_mode ? ch_last : (row_trig && !row_busy));

  vsa_burst #(.LEN_W(LEN_W), .SETUP_CYC(SETUP_CYC)) u_line (
    .clk(clk), .rst_n(rst_n_i), .start(ln_start), .len(bytes_per_line),
    .take(gnt[IX_LINE]), .active(act[IX_LINE]), .in_setup(ln_set), .last(ln_last));

  vsa_burst #(.LEN_W(REF_W), .SETUP_CYC(0)) u_ref (
    .clk(clk), .rst_n(rst_n_i), .start(line_start), .len(refresh_cnt),
    .take(gnt[IX_REF]), .active(act[IX_REF]), .in_setup(), .last(rf_last));

  vsa_burst #(.LEN_W(LEN_W), .SETUP_CYC(SETUP_CYC)) u_char (
    .clk(clk), .rst_n(rst_n_i), .start(ch_start), .len(bytes_per_line),
    .take(gnt[IX_CHAR]), .active(act[IX_CHAR]), .in_setup(ch_set), .last(ch_last));

  vsa_burst #(.LEN_W(LEN_W), .SETUP_CYC(SETUP_CYC)) u_attr (
    .clk(clk), .rst_n(rst_n_i), .start(at_start), .len(bytes_per_line),
    .take(gnt[IX_ATTR]), .active(act[IX_ATTR]), .in_setup(at_set), .last(at_last));

  assign act[IX_DMA] = dma_req;

  // lowest set bit wins: fixed priority
  assign gnt = act & (~act + NUM_CLIENTS'(1));
  assign setup_slot = (gnt[IX_LINE] && ln_set) || (gnt[IX_CHAR] && ch_set) ||
                      (gnt[IX_ATTR] && at_set);

  logic            cd_d, ad_d;
  logic [DC_W-1:0] dc_d;
  always_comb begin
    cd_d = ch_last;
    ad_d = at_last;
    dc_d = dma_frame_cnt;
    if (frame_start)       dc_d = '0;
    else if (gnt[IX_DMA])  dc_d = dma_frame_cnt + DC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      char_done     <= 1'b0;
      attr_done     <= 1'b0;
      dma_frame_cnt <= '0;
    end else begin
      char_done     <= cd_d;
      attr_done     <= ad_d;
      dma_frame_cnt <= dc_d;
    end
  end

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(gnt));
  // R2
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    act[IX_LINE] |-> gnt[IX_LINE]);
  // R2
  ref_over_row_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (act[IX_REF] && !act[IX_LINE]) |-> gnt[IX_REF]);
  // R4
  refresh_load_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (line_start && refresh_cnt != '0) |=> act[IX_REF]);
  // R9
  char_done_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    char_done |-> $past(gnt[IX_CHAR]));
  // R10
  dma_leftover_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (dma_req && act[IX_ATTR:IX_LINE] == '0) |-> gnt[IX_DMA]);
  // R11
  dma_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    frame_start |=> (dma_frame_cnt == '0));
endmodule

// File: tb/tb_vram_slot_arbiter.sv
module tb_vram_slot_arbiter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic i_ls, i_disp, i_vb, i_dreq;
  logic c_text, c_attr;
  logic [7:0]  c_bpl;
  logic [4:0]  c_ref;
  logic [4:0]  c_ch;
  logic [6:0]  c_rows;
  logic [4:0]  gnt;
  logic        setup_slot, char_done, attr_done;
  logic [15:0] dcnt;

  vram_slot_arbiter dut (
    .clk(clk), .rst_n(rst_n), .line_start(i_ls), .in_display(i_disp),
    .vblank(i_vb), .dma_req(i_dreq), .text_mode(c_text), .attr_en(c_attr),
    .bytes_per_line(c_bpl), .refresh_cnt(c_ref), .char_height(c_ch),
    .rows(c_rows), .gnt(gnt), .setup_slot(setup_slot), .char_done(char_done),
    .attr_done(attr_done), .dma_frame_cnt(dcnt));

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // reference model state
  int m_ls, m_lr, m_rr, m_cs, m_cr, m_as, m_ar;
  int m_vbq, m_lin, m_rows, m_cd, m_ad, m_dc;
  int done_seen;

  function automatic logic [4:0] mgnt();
    logic [4:0] a;
    a[0] = (m_ls + m_lr) != 0;
    a[1] = m_rr != 0;
    a[2] = (m_cs + m_cr) != 0;
    a[3] = (m_as + m_ar) != 0;
    a[4] = i_dreq;
    for (int k = 0; k < 5; k++) if (a[k]) return 5'(1 << k);
    return 5'd0;
  endfunction

  function automatic int nact();
    return int'((m_ls + m_lr) != 0) + int'(m_rr != 0) + int'((m_cs + m_cr) != 0) +
           int'((m_as + m_ar) != 0);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [4:0] g;
    bit clast, alast, fs, trig, busy, cst, ast;
    g = mgnt();
    clast = g[2] && (m_cs + m_cr == 1);
    alast = g[3] && (m_as + m_ar == 1);
    busy  = (m_cs + m_cr + m_as + m_ar) != 0;
    fs = i_vb && (m_vbq == 0);
    trig = 0;
    if (fs) begin
      m_lin = 0; m_rows = 1; trig = 1;
    end else if (i_ls && i_disp) begin
      if (m_lin == int'(c_ch) - 1) begin
        m_lin = 0;
        if (m_rows <= int'(c_rows)) begin trig = 1; m_rows++; end
      end else m_lin++;
    end
    cst = trig && c_text && !busy;
    ast = c_attr && ((m_as + m_ar) == 0) && (c_text ? clast : (trig && !busy));
    if (i_ls && i_disp) begin m_ls = 2; m_lr = int'(c_bpl); end
    else if (g[0]) begin if (m_ls > 0) m_ls--; else m_lr--; end
    if (i_ls) m_rr = int'(c_ref);
    else if (g[1]) m_rr--;
    if (cst) begin m_cs = 2; m_cr = int'(c_bpl); end
    else if (g[2]) begin if (m_cs > 0) m_cs--; else m_cr--; end
    if (ast) begin m_as = 2; m_ar = int'(c_bpl); end
    else if (g[3]) begin if (m_as > 0) m_as--; else m_ar--; end
    m_cd = int'(clast);
    m_ad = int'(alast);
    m_dc = fs ? 0 : ((m_dc + int'(g[4])) & 16'hffff);
    m_vbq = int'(i_vb);
  endtask

  task automatic compare();
    logic [4:0] eg;
    bit es;
    string tg;
    eg = mgnt();
    es = (eg[0] && m_ls > 0) || (eg[2] && m_cs > 0) || (eg[3] && m_as > 0);
    chk($onehot0(gnt), "R1", int'(gnt), int'(eg));
    if (nact() > 1)       tg = "R2";
    else if (eg[0])       tg = "R3";
    else if (eg[1])       tg = "R4";
    else if (eg[2])       tg = "R6";
    else if (eg[3])       tg = c_text ? "R6" : "R7";
    else                  tg = "R10";
    chk(gnt == eg, tg, int'(gnt), int'(eg));
    chk(setup_slot == es, "R3", int'(setup_slot), int'(es));
    chk(int'(char_done) == m_cd, "R9", int'(char_done), m_cd);
    chk(int'(attr_done) == m_ad, "R9", int'(attr_done), m_ad);
    chk(int'(dcnt) == m_dc, "R11", int'(dcnt), m_dc);
    if (char_done) done_seen++;
  endtask

  task automatic tick(input bit ls, input bit disp, input bit vb, input bit dr);
    @(negedge clk);
    model_step();
    compare();
    i_ls = ls; i_disp = disp; i_vb = vb; i_dreq = dr;
  endtask

  task automatic run_frame(input int nblank, input int ndisp, input int llen, input int dpct);
    for (int l = 0; l < nblank + ndisp; l++)
      for (int c = 0; c < llen; c++)
        tick(c == 0, l >= nblank, l < nblank, ($urandom % 100) < dpct);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; i_ls = 0; i_disp = 0; i_vb = 0; i_dreq = 0;
    c_text = 1; c_attr = 0; c_bpl = 8'd10; c_ref = 5'd2; c_ch = 5'd2; c_rows = 7'd3;
    m_ls = 0; m_lr = 0; m_rr = 0; m_cs = 0; m_cr = 0; m_as = 0; m_ar = 0;
    m_vbq = 0; m_lin = 0; m_rows = 0; m_cd = 0; m_ad = 0; m_dc = 0; done_seen = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(gnt == 5'd0, "R12", int'(gnt), 0);
    chk(!setup_slot && !char_done && !attr_done, "R12", int'(setup_slot), 0);
    chk(dcnt == 16'd0, "R12", int'(dcnt), 0);
    @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 5; k++) tick(0, 0, 0, 0);

    // R5 directed: long lines, rows+1 character bursts per frame
    run_frame(2, 4, 200, 50);
    done_seen = 0;
    run_frame(3, 12, 200, 50);
    chk(done_seen == int'(c_rows) + 1, "R5", done_seen, int'(c_rows) + 1);

    // R8 directed: bursts overrun short lines, row triggers dropped
    c_attr = 1; c_ch = 5'd1; c_rows = 7'd5; c_bpl = 8'd80;
    done_seen = 0;
    run_frame(3, 10, 60, 30);
    chk(done_seen >= 1 && done_seen < int'(c_rows) + 1, "R8", done_seen, int'(c_rows));

    // R7 directed: bitmap mode with attributes
    c_text = 0; c_attr = 1; c_bpl = 8'd20; c_ch = 5'd2; c_rows = 7'd2;
    run_frame(4, 8, 150, 60);

    // constrained random frames
    for (int f = 0; f < 14; f++) begin
      c_text = 1'($urandom % 2);
      c_attr = 1'($urandom % 2);
      c_bpl  = 8'($urandom_range(0, 100));
      c_ref  = 5'($urandom_range(0, 8));
      c_ch   = 5'($urandom_range(1, 4));
      c_rows = 7'($urandom_range(1, 6));
      run_frame($urandom_range(2, 4), $urandom_range(6, 14),
                $urandom_range(40, 220), $urandom_range(0, 100));
    end
    tick(0, 0, 0, 0);
    summary();
  end
endmodule